// File: doc/BRIEF.md
# SDLC Receive Frame Status FIFO

This block sits beside an SDLC receiver and records, for every frame that closes, how many bytes the frame carried and which receive errors were seen while it was arriving. A byte strobe advances a per-frame length counter, error inputs are accumulated into sticky per-frame flags, and an end-of-frame strobe pushes the length and flags as one entry into a ten-deep queue before clearing both for the next frame.

Because the lengths are kept apart from the data, a DMA engine can stream received bytes to memory back to back while software catches up later. Software reads the head entry through a combinational read port, pops it with a read strobe, and uses the entry's valid bit plus the empty and full indications to walk the queue. An enable input gates the whole function; while it is low nothing is recorded and the queue is flushed.

Top module: `sdlc_frm_stat_fifo`

## Requirements
- R1: After reset the queue is empty (empty=1, full=0), the overflow flag is 0 and the read word is all zero.
- R2: The length field, read word bits [13:0], equals the number of cycles with the byte strobe high since the previous end-of-frame cycle (exclusive) up to and including the end-of-frame cycle; the next frame counts from zero.
- R3: The length counter saturates at 16383 and does not wrap.
- R4: Read word bit 14 (overrun), bit 15 (parity) and bit 16 (CRC) are set in an entry when the matching error input was high in any cycle of that frame, including its end-of-frame cycle; the flags start clear for the next frame.
- R5: Entries are read oldest first; the queue holds up to 10 entries and full is 1 exactly when 10 are stored.
- R6: The read word shows the head entry with bit 17 (valid) set; when the queue is empty the whole word is zero, and a read strobe then changes nothing.
- R7: An end-of-frame and a read strobe in the same cycle both take effect, also when the queue is full, and the occupancy stays the same.
- R8: An end-of-frame while the queue is full and no read strobe is present loses the entry and sets the overflow flag, which stays set while enable is high.
- R9: While enable is low, byte, end-of-frame, error and read inputs have no effect, the queue is emptied, the length counter and error flags are cleared and the overflow flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Function enable |
| byte_stb | input | 1 | One received byte this cycle |
| eof_stb | input | 1 | Frame closes this cycle |
| err_ovr | input | 1 | Receive overrun seen |
| err_par | input | 1 | Parity error seen |
| err_crc | input | 1 | CRC error seen |
| rd_stb | input | 1 | Pop the head entry |
| rd_data | output | 18 | Head entry: valid, CRC, parity, overrun, length |
| empty | output | 1 | No entries stored |
| full | output | 1 | Ten entries stored |
| ovfl | output | 1 | Sticky entry-lost flag |

## Verification
Frames of every length from zero to a few dozen bytes are sent with all eight error combinations, with the error placed either on a byte cycle or on the closing cycle and with a byte either included in or left out of the closing cycle; this separates counting off-by-one faults and flag clearing faults. Reads are interleaved so that pushes and pops coincide at low occupancy and at full, which tells a correct simultaneous update apart from a lost or doubled entry. A fill past ten entries distinguishes dropping from overwriting, a very long frame exposes wrapping versus saturation, and traffic while disabled shows whether anything leaks into the queue.

// File: rtl/fsf_pkg.sv
package fsf_pkg;
  typedef struct packed {
    logic crc;
    logic par;
    logic ovr;
  } fsf_err_t;

  localparam int unsigned ERR_W = $bits(fsf_err_t);
endpackage

// File: rtl/fsf_rst_sync.sv
module fsf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/fsf_len_cnt.sv
module fsf_len_cnt
  import fsf_pkg::*;
#(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             byte_stb,
  input  logic             eof_stb,
  input  fsf_err_t         err_in,
  output logic [CNT_W-1:0] cnt_close,
  output fsf_err_t         err_close
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  fsf_err_t         err_q, err_d;
  logic             cnt_ce, err_ce;

  always_comb begin
    cnt_close = cnt_q;
    if (byte_stb && (cnt_q != CNT_MAX)) cnt_close = cnt_q + 1'b1;
    err_close = fsf_err_t'(err_q | err_in);
  end

  always_comb begin
    cnt_ce = !en || eof_stb || byte_stb;
    err_ce = !en || eof_stb || (err_in != '0);
    if (!en || eof_stb) begin
      cnt_d = '0;
      err_d = '0;
    end else begin
      cnt_d = cnt_close;
      err_d = err_close;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= '0;
    end else begin
      if (cnt_ce) cnt_q <= cnt_d;
      if (err_ce) err_q <= err_d;
    end
  end
endmodule

// File: rtl/fsf_store.sv
module fsf_store #(
  parameter int unsigned DEPTH = 10,
  parameter int unsigned ENT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [ENT_W-1:0] wdata,
  output logic [ENT_W-1:0] rdata,
  output logic             empty,
  output logic             full,
  output logic             drop
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned OCC_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [OCC_W-1:0] OCC_FULL = OCC_W'(DEPTH);

  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [OCC_W-1:0] occ_q, occ_d;
  logic             do_push, do_pop;
  logic [ENT_W-1:0] slot [DEPTH];

  assign empty   = (occ_q == '0);
  assign full    = (occ_q == OCC_FULL);
  assign do_pop  = pop && !empty && !flush;
  assign do_push = push && !flush && (!full || do_pop);
  assign drop    = push && !flush && full && !do_pop;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    occ_d = occ_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      occ_d = '0;
    end else begin
      if (do_push) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop) occ_d = occ_q + 1'b1;
      if (do_pop && !do_push) occ_d = occ_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      occ_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      occ_q <= occ_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic             we;
    logic [ENT_W-1:0] ent_q;
    assign we = do_push && (wr_q == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (we) ent_q <= wdata;
    end
    assign slot[i] = ent_q;
  end

  assign rdata = slot[rd_q];
endmodule

// File: rtl/sdlc_frm_stat_fifo.sv
module sdlc_frm_stat_fifo
  import fsf_pkg::*;
#(
  parameter int unsigned CNT_W  = 14,
  parameter int unsigned DEPTH  = 10,
  parameter int unsigned WORD_W = CNT_W + ERR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              byte_stb,
  input  logic              eof_stb,
  input  logic              err_ovr,
  input  logic              err_par,
  input  logic              err_crc,
  input  logic              rd_stb,
  output logic [WORD_W-1:0] rd_data,
  output logic              empty,
  output logic              full,
  output logic              ovfl
);
  localparam int unsigned ENT_W = CNT_W + ERR_W;

  logic             rst_n_s;
  fsf_err_t         err_in, err_close;
  logic [CNT_W-1:0] cnt_close;
  logic [ENT_W-1:0] ent_w, ent_r;
  logic             drop;
  logic             ovfl_q, ovfl_d;

  assign err_in = '{crc: err_crc, par: err_par, ovr: err_ovr};

  fsf_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  fsf_len_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .en        (en),
    .byte_stb  (byte_stb),
    .eof_stb   (eof_stb),
    .err_in    (err_in),
    .cnt_close (cnt_close),
    .err_close (err_close)
  );

  assign ent_w = {err_close, cnt_close};

  fsf_store #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n_s),
    .flush (!en),
    .push  (eof_stb),
    .pop   (rd_stb),
    .wdata (ent_w),
    .rdata (ent_r),
    .empty (empty),
    .full  (full),
    .drop  (drop)
  );

  always_comb begin
    ovfl_d = ovfl_q | drop;
    if (!en) ovfl_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) ovfl_q <= 1'b0;
    else          ovfl_q <= ovfl_d;
  end

  assign ovfl    = ovfl_q;
  assign rd_data = empty ? '0 : {1'b1, ent_r};
endmodule

// File: rtl/fsf_chk.sv
module fsf_chk #(
  parameter int unsigned WORD_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              eof_stb,
  input logic              rd_stb,
  input logic [WORD_W-1:0] rd_data,
  input logic              empty,
  input logic              full,
  input logic              ovfl
);
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R5
  AST_EMPTY_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (rd_data == '0)); // R6
  AST_NONEMPTY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !empty |-> rd_data[WORD_W-1]); // R6
  AST_PUSH_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    (en && eof_stb && !rd_stb) |=> !empty); // R5
  AST_EMPTY_READ_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && empty && !eof_stb) |=> empty); // R6
  AST_FULL_PUSHPOP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && full && eof_stb && rd_stb) |=> full); // R7
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (en && full && eof_stb && !rd_stb) |=> ovfl); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ovfl) |=> ovfl); // R8
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (empty && !ovfl)); // R9
endmodule

bind sdlc_frm_stat_fifo fsf_chk #(.WORD_W(WORD_W)) u_fsf_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .eof_stb (eof_stb),
  .rd_stb  (rd_stb),
  .rd_data (rd_data),
  .empty   (empty),
  .full    (full),
  .ovfl    (ovfl)
);

// File: tb/tb_sdlc_frm_stat_fifo.sv
module tb_sdlc_frm_stat_fifo;
  localparam int CNT_W  = 14;
  localparam int DEPTH  = 10;
  localparam int WORD_W = 18;
  localparam int CMAX   = 16383;

  logic clk, rst_n, en, byte_stb, eof_stb, err_ovr, err_par, err_crc, rd_stb;
  logic [WORD_W-1:0] rd_data;
  logic empty, full, ovfl;

  sdlc_frm_stat_fifo dut (
    .clk(clk), .rst_n(rst_n), .en(en), .byte_stb(byte_stb), .eof_stb(eof_stb),
    .err_ovr(err_ovr), .err_par(err_par), .err_crc(err_crc), .rd_stb(rd_stb),
    .rd_data(rd_data), .empty(empty), .full(full), .ovfl(ovfl)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [WORD_W-1:0] mq[$];
  int               mcnt = 0;
  logic [2:0]       merr = '0;
  logic             movf = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // er: bit0 overrun, bit1 parity, bit2 CRC
  task automatic cyc(input logic b, input logic e, input logic [2:0] er,
                     input logic r, input string tag);
    logic [WORD_W-1:0] ew;
    byte_stb = b; eof_stb = e; rd_stb = r;
    {err_crc, err_par, err_ovr} = er;
    if (!en) begin
      mq.delete(); mcnt = 0; merr = '0; movf = 1'b0;
    end else begin
      int close;
      logic [2:0] ce;
      bit wasfull, popd;
      close   = (b && mcnt < CMAX) ? mcnt + 1 : mcnt;
      ce      = merr | er;
      wasfull = (mq.size() == DEPTH);
      popd    = 0;
      if (r && mq.size() > 0) begin
        void'(mq.pop_front());
        popd = 1;
      end
      if (e) begin
        if (wasfull && !popd) movf = 1'b1;
        else mq.push_back({1'b1, ce, close[CNT_W-1:0]});
        mcnt = 0; merr = '0;
      end else begin
        mcnt = close; merr = ce;
      end
    end
    @(posedge clk);
    @(negedge clk);
    byte_stb = 0; eof_stb = 0; rd_stb = 0;
    {err_crc, err_par, err_ovr} = '0;
    ew = (mq.size() > 0) ? mq[0] : '0;
    chk(tag, {11'd0, rd_data, empty, full, ovfl},
             {11'd0, ew, (mq.size() == 0), (mq.size() == DEPTH), movf});
  endtask

  task automatic frame(input int len, input logic [2:0] er, input bit err_on_eof,
                       input bit byte_on_eof, input bit rd_on_eof, input string tag);
    for (int j = 0; j < len; j++)
      cyc(1'b1, 1'b0, (!err_on_eof && j == 0) ? er : 3'b000, 1'b0, tag);
    cyc(byte_on_eof, 1'b1, (err_on_eof || len == 0) ? er : 3'b000, rd_on_eof, tag);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; en = 0; byte_stb = 0; eof_stb = 0; rd_stb = 0;
    err_ovr = 0; err_par = 0; err_crc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", {11'd0, rd_data, empty, full, ovfl}, {11'd0, 18'd0, 1'b1, 1'b0, 1'b0});

    en = 1;
    // R2 R4 sweep of lengths and error combinations, R7 push with pop at low occupancy
    for (int len = 0; len < 24; len++) begin
      frame(len, 3'(len % 8), (len % 4) >= 2, len[0], (len % 3) == 0, "R2 R4 R7");
      if ((len % 3) != 0) cyc(1'b0, 1'b0, 3'b000, 1'b1, "R5 R6");
    end
    // errors only on the closing cycle for every combination
    for (int k = 0; k < 8; k++) frame(2, 3'(k), 1'b1, 1'b0, 1'b0, "R4");
    // R5 drain oldest first, R6 read while empty
    while (mq.size() > 0) cyc(1'b0, 1'b0, 3'b000, 1'b1, "R5");
    cyc(1'b0, 1'b0, 3'b000, 1'b1, "R6");
    cyc(1'b0, 1'b0, 3'b000, 1'b1, "R6");

    // R5 fill to full
    for (int i = 0; i < DEPTH; i++) frame(i + 1, 3'(i % 8), 1'b0, 1'b0, 1'b0, "R5");
    // R8 overflow drops entries
    frame(5, 3'b111, 1'b0, 1'b0, 1'b0, "R8");
    cyc(1'b0, 1'b1, 3'b000, 1'b0, "R8");
    // R7 push and pop at full
    frame(7, 3'b010, 1'b0, 1'b1, 1'b1, "R7");
    cyc(1'b1, 1'b1, 3'b001, 1'b1, "R7");
    while (mq.size() > 0) cyc(1'b0, 1'b0, 3'b000, 1'b1, "R5 R8");

    // R9 disabled: inputs ignored, queue and flags cleared
    frame(3, 3'b000, 1'b0, 1'b0, 1'b0, "R9");
    cyc(1'b1, 1'b0, 3'b101, 1'b0, "R9");
    en = 0;
    for (int i = 0; i < 6; i++) cyc(1'b1, i[0], 3'b111, i[1], "R9");
    en = 1;
    frame(3, 3'b000, 1'b0, 1'b0, 1'b0, "R9");
    cyc(1'b0, 1'b0, 3'b000, 1'b1, "R9");

    // R3 saturation
    frame(CMAX + 7, 3'b000, 1'b0, 1'b1, 1'b0, "R3");
    frame(4, 3'b000, 1'b0, 1'b0, 1'b0, "R3");
    cyc(1'b0, 1'b0, 3'b000, 1'b1, "R3");
    cyc(1'b0, 1'b0, 3'b000, 1'b1, "R3");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule